// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked system and an external asynchronous static RAM of 131,072 words by 8 bits. It takes one read or one write request at a time. It turns each request into a sequence of chip-select, write-strobe and output-strobe phases. Each phase lasts long enough to meet the memory's setup, pulse-width, access and bus-release times. Every phase length is a whole number of system clock cycles. The lengths come from a clock-period parameter and a set of nanosecond timing parameters, so one design covers fast and slow memory grades.

The system side uses a simple handshake. `ready_o` is high only when the controller is idle. A request is taken on a clock edge where both `req_i` and `ready_o` are high. Read results come back in a register together with a one-cycle valid pulse. On the memory side the controller drives the address and the three active-low strobes. Write data goes out on a separate output bus with its own driver enable, so the pad ring can build the shared data bus.

Two rules keep the shared data bus free of contention. The output strobe stays high during every write. After a read, a short turnaround phase comes before the next write drives the bus.

Top module: `sram_seq_ctrl`

## Requirements
- R1: While idle (and right after reset), `ready_o` is 1, chip select, write strobe and output strobe are all high (inactive), the data driver enable is 0 and `rd_valid_o` is 0.
- R2: A request is accepted on a rising clock edge where `req_i` and `ready_o` are both 1. From the cycle after acceptance until the controller is idle again, `ready_o` is 0.
- R3: In a write, chip select and write strobe are low for exactly WP cycles. During those cycles the output strobe is high, the driver enable is 1, the accepted data is on the data output and the accepted address is on the address output. One further cycle follows with the write strobe high, chip select still low and the data still driven.
- R4: Data written to an address is returned by a later read of that address.
- R5: In a read, chip select and output strobe are low and the write strobe is high for exactly RD cycles, with the driver enable at 0 and the accepted address on the address output.
- R6: The read data is sampled from the memory bus at the clock edge that ends the last read cycle. It is presented on `rd_data_o` with `rd_valid_o` high for exactly one cycle, the cycle right after that edge.
- R7: A write accepted when the previous accepted request was a read starts with a turnaround phase of TA cycles. In that phase all three strobes are high and the driver enable is 0. Only after it does the write strobe fall.
- R8: A write accepted after a write, or as the first request after reset, has no turnaround: the write strobe falls in the first cycle after acceptance.
- R9: The output strobe is never low while the write strobe is low or while the data drivers are enabled.
- R10: The address output does not change while chip select stays low.
- R11: Cycle counts use ceiling division by the clock period, with a minimum of 1:
  - WP is the largest of the write-pulse time, the data-setup time and the cycle time minus one cycle.
  - RD is the largest of the address-access time, the output-enable-access time and the cycle time.
  - TA is the output-release time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request strobe |
| req_we_i | input | 1 | 1 = write request, 0 = read request |
| req_addr_i | input | 17 | Word address of the request |
| req_wdata_i | input | 8 | Data for a write request |
| ready_o | output | 1 | Controller idle, can accept a request |
| rd_data_o | output | 8 | Registered read result |
| rd_valid_o | output | 1 | One-cycle pulse marking `rd_data_o` valid |
| sram_addr_o | output | 17 | Memory address |
| sram_ce_n_o | output | 1 | Memory chip select, active low |
| sram_we_n_o | output | 1 | Memory write strobe, active low |
| sram_oe_n_o | output | 1 | Memory output strobe, active low |
| sram_dq_o | output | 8 | Data toward the memory |
| sram_dq_oe_o | output | 1 | Enable for the data drivers toward the memory |
| sram_dq_i | input | 8 | Data from the memory bus |

## Verification
The hardest case to reach is the read-to-write turnaround, and with it the rule that the driver never turns on while the output strobe is low. It only appears when a write follows a read, so the stimulus alternates reads and writes. Some writes are issued in the first idle cycle after a read completes, and other writes come back to back. The bench uses a slower memory grade so that every phase spans two or three cycles and the phase counter is really exercised. The bench memory model also returns a poison value until the full access time has passed, so sampling too early shows up as a data mismatch.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE     = 3'd0,
      ST_TURN     = 3'd1,
      ST_WR_PULSE = 3'd2,
      ST_WR_END   = 3'd3,
      ST_RD       = 3'd4
   } seq_state_t;

   // ceiling of t/p, never below one cycle
   function automatic int ns_to_cyc(input int t_ns, input int p_ns);
      int c;
      c = (t_ns + p_ns - 1) / p_ns;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
   parameter int N_MAX = 1,
   parameter int LD_W  = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load_i,
   input  logic [LD_W-1:0] load_val_i,
   output logic            expired_o
);

   generate
      if (N_MAX <= 1) begin : g_fixed
         // every phase is a single cycle: no counter needed
         logic unused_tmr;
         assign unused_tmr = ^{clk, rst_n, load_i, load_val_i};
         assign expired_o  = 1'b1;
      end else begin : g_count
         logic [LD_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (load_i)
               cnt_q <= load_val_i;
            else if (cnt_q != '0)
               cnt_q <= cnt_q - 1'b1;
         end
         assign expired_o = (cnt_q == '0);
      end
   endgenerate

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture_i,
   input  logic [DATA_W-1:0] bus_i,
   output logic [DATA_W-1:0] data_o,
   output logic              valid_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_o  <= '0;
         valid_o <= 1'b0;
      end else begin
         valid_o <= capture_i;
         if (capture_i)
            data_o <= bus_i;
      end
   end

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
   import sram_seq_pkg::*;
#(
   parameter int ADDR_W        = 17,
   parameter int DATA_W        = 8,
   parameter int CLK_PERIOD_NS = 20,
   parameter int T_RC_NS       = 10,
   parameter int T_AA_NS       = 10,
   parameter int T_OE_NS       = 5,
   parameter int T_WP_NS       = 7,
   parameter int T_DW_NS       = 5,
   parameter int T_HZ_NS       = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic              req_we_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   input  logic [DATA_W-1:0] req_wdata_i,
   output logic              ready_o,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              rd_valid_o,
   output logic [ADDR_W-1:0] sram_addr_o,
   output logic              sram_ce_n_o,
   output logic              sram_we_n_o,
   output logic              sram_oe_n_o,
   output logic [DATA_W-1:0] sram_dq_o,
   output logic              sram_dq_oe_o,
   input  logic [DATA_W-1:0] sram_dq_i
);

   localparam int N_WP  = imax(imax(ns_to_cyc(T_WP_NS, CLK_PERIOD_NS),
                                    ns_to_cyc(T_DW_NS, CLK_PERIOD_NS)),
                               imax(ns_to_cyc(T_RC_NS, CLK_PERIOD_NS) - 1, 1));
   localparam int N_RD  = imax(imax(ns_to_cyc(T_AA_NS, CLK_PERIOD_NS),
                                    ns_to_cyc(T_OE_NS, CLK_PERIOD_NS)),
                               ns_to_cyc(T_RC_NS, CLK_PERIOD_NS));
   localparam int N_TA  = ns_to_cyc(T_HZ_NS, CLK_PERIOD_NS);
   localparam int N_MAX = imax(imax(N_WP, N_RD), N_TA);
   localparam int LD_W  = (N_MAX > 1) ? $clog2(N_MAX) : 1;

   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("sram_seq_ctrl: ADDR_W and DATA_W must be positive");
      end
      if (CLK_PERIOD_NS < 1) begin : g_bad_clk
         $error("sram_seq_ctrl: CLK_PERIOD_NS must be at least 1");
      end
      if (T_RC_NS < 0 || T_AA_NS < 0 || T_OE_NS < 0 || T_WP_NS < 0 ||
          T_DW_NS < 0 || T_HZ_NS < 0) begin : g_bad_timing
         $error("sram_seq_ctrl: timing parameters must not be negative");
      end
   endgenerate

   seq_state_t        st_q, st_d;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdat_q;
   logic              last_rd_q;
   logic              accept;
   logic              tmr_load, tmr_exp;
   logic [LD_W-1:0]   tmr_val;
   logic              rd_cap;

   assign ready_o = (st_q == ST_IDLE);
   assign accept  = req_i && ready_o;
   assign rd_cap  = (st_q == ST_RD) && tmr_exp;

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_IDLE: if (accept)
                     st_d = !req_we_i ? ST_RD : (last_rd_q ? ST_TURN : ST_WR_PULSE);
         ST_TURN:     if (tmr_exp) st_d = ST_WR_PULSE;
         ST_WR_PULSE: if (tmr_exp) st_d = ST_WR_END;
         ST_WR_END:   st_d = ST_IDLE;
         ST_RD:       if (tmr_exp) st_d = ST_IDLE;
         default:     st_d = ST_IDLE;
      endcase
   end

   always_comb begin
      tmr_load = (st_d != st_q);
      case (st_d)
         ST_TURN:     tmr_val = LD_W'(N_TA - 1);
         ST_WR_PULSE: tmr_val = LD_W'(N_WP - 1);
         ST_RD:       tmr_val = LD_W'(N_RD - 1);
         default:     tmr_val = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         addr_q    <= '0;
         wdat_q    <= '0;
         last_rd_q <= 1'b0;
      end else begin
         st_q <= st_d;
         if (accept) begin
            addr_q    <= req_addr_i;
            wdat_q    <= req_wdata_i;
            last_rd_q <= !req_we_i;
         end
      end
   end

   // strobe decode: {ce_n, we_n, oe_n, drive}
   always_comb begin
      case (st_q)
         ST_WR_PULSE: {sram_ce_n_o, sram_we_n_o, sram_oe_n_o, sram_dq_oe_o} = 4'b0011;
         ST_WR_END:   {sram_ce_n_o, sram_we_n_o, sram_oe_n_o, sram_dq_oe_o} = 4'b0111;
         ST_RD:       {sram_ce_n_o, sram_we_n_o, sram_oe_n_o, sram_dq_oe_o} = 4'b0100;
         default:     {sram_ce_n_o, sram_we_n_o, sram_oe_n_o, sram_dq_oe_o} = 4'b1110;
      endcase
   end

   assign sram_addr_o = addr_q;
   assign sram_dq_o   = wdat_q;

   sram_phase_timer #(
      .N_MAX (N_MAX),
      .LD_W  (LD_W)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (tmr_load),
      .load_val_i (tmr_val),
      .expired_o  (tmr_exp)
   );

   sram_rd_capture #(
      .DATA_W (DATA_W)
   ) u_capture (
      .clk       (clk),
      .rst_n     (rst_n),
      .capture_i (rd_cap),
      .bus_i     (sram_dq_i),
      .data_o    (rd_data_o),
      .valid_o   (rd_valid_o)
   );

endmodule

// File: rtl/sram_seq_ctrl_chk.sv
module sram_seq_ctrl_chk #(
   parameter int ADDR_W = 17
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ready_o,
   input logic              rd_valid_o,
   input logic [ADDR_W-1:0] sram_addr_o,
   input logic              sram_ce_n_o,
   input logic              sram_we_n_o,
   input logic              sram_oe_n_o,
   input logic              sram_dq_oe_o
);

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ready_o |-> (sram_ce_n_o && sram_we_n_o && sram_oe_n_o && !sram_dq_oe_o)); // R1

   AST_WE_WITH_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_we_n_o |-> (!sram_ce_n_o && sram_dq_oe_o)); // R3

   AST_COMMIT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sram_we_n_o) |-> (!sram_ce_n_o && sram_dq_oe_o)); // R3

   AST_RVALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid_o |=> !rd_valid_o); // R6

   AST_DRIVE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sram_dq_oe_o) |-> $past(sram_oe_n_o)); // R7

   AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
      sram_dq_oe_o |-> sram_oe_n_o); // R9

   AST_OE_OFF_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_we_n_o |-> sram_oe_n_o); // R9

   AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!sram_ce_n_o && $past(!sram_ce_n_o)) |-> $stable(sram_addr_o)); // R10

endmodule

bind sram_seq_ctrl sram_seq_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .ready_o      (ready_o),
   .rd_valid_o   (rd_valid_o),
   .sram_addr_o  (sram_addr_o),
   .sram_ce_n_o  (sram_ce_n_o),
   .sram_we_n_o  (sram_we_n_o),
   .sram_oe_n_o  (sram_oe_n_o),
   .sram_dq_oe_o (sram_dq_oe_o)
);

// File: tb/sram_seq_ctrl_tb_top.sv
module sram_seq_ctrl_tb_top;

   localparam int AW = 17;
   localparam int DW = 8;
   // slower memory grade on a 20 ns clock; expected counts per R11:
   // WP = max(ceil(35/20), ceil(20/20), ceil(45/20)-1) = 2
   // RD = max(ceil(45/20), ceil(25/20), ceil(45/20))   = 3
   // TA = ceil(25/20)                                  = 2
   localparam int EXP_WP = 2;
   localparam int EXP_RD = 3;
   localparam int EXP_TA = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req = 1'b0;
   logic          req_we = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          ready;
   logic [DW-1:0] rd_data;
   logic          rd_valid;
   logic [AW-1:0] m_addr;
   logic          m_ce_n, m_we_n, m_oe_n, m_dq_oe;
   logic [DW-1:0] m_dq_out;
   logic [DW-1:0] m_dq_in;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;
   bit last_was_rd = 1'b0;

   logic [DW-1:0] mem_model [int];
   logic [DW-1:0] ref_mem   [int];
   logic [DW-1:0] exp_q     [$];
   int            rd_age = 0;

   always #10 clk = ~clk;

   sram_seq_ctrl #(
      .ADDR_W(AW), .DATA_W(DW), .CLK_PERIOD_NS(20),
      .T_RC_NS(45), .T_AA_NS(45), .T_OE_NS(25),
      .T_WP_NS(35), .T_DW_NS(20), .T_HZ_NS(25)
   ) dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_i(req), .req_we_i(req_we), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
      .ready_o(ready), .rd_data_o(rd_data), .rd_valid_o(rd_valid),
      .sram_addr_o(m_addr), .sram_ce_n_o(m_ce_n), .sram_we_n_o(m_we_n),
      .sram_oe_n_o(m_oe_n), .sram_dq_o(m_dq_out), .sram_dq_oe_o(m_dq_oe),
      .sram_dq_i(m_dq_in)
   );

   // memory model: commit on rising write strobe, data only after full access time
   always @(posedge m_we_n) begin
      if (!m_ce_n && m_dq_oe)
         mem_model[int'(m_addr)] = m_dq_out;
   end

   always @(posedge clk) begin
      if (!m_ce_n && !m_oe_n && m_we_n) rd_age <= rd_age + 1;
      else                              rd_age <= 0;
   end

   always_comb begin
      if (!m_ce_n && !m_oe_n && m_we_n && rd_age >= EXP_RD - 1)
         m_dq_in = mem_model.exists(int'(m_addr)) ? mem_model[int'(m_addr)] : 8'h00;
      else
         m_dq_in = 8'hEE;
   end

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // {ready, ce_n, we_n, oe_n, dq_oe}
   function automatic logic [4:0] pins();
      return {ready, m_ce_n, m_we_n, m_oe_n, m_dq_oe};
   endfunction

   task automatic issue(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      while (!ready) @(negedge clk);
      req = 1'b1; req_we = we; req_addr = a; req_wdata = d;
      @(negedge clk);          // first cycle after acceptance (R2)
      req = 1'b0;
   endtask

   task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      bit turn;
      turn = last_was_rd;
      issue(1'b1, a, d);
      if (turn) begin
         for (int i = 0; i < EXP_TA; i++) begin
            check(pins() == 5'b01110, "R7 turnaround strobes", pins(), 5'b01110);
            @(negedge clk);
         end
      end
      // R8: without a turnaround the write strobe is already low here
      for (int i = 0; i < EXP_WP; i++) begin
         check(pins() == 5'b00011, turn ? "R3 write pulse" : "R8 write pulse no turnaround",
               pins(), 5'b00011);
         check(m_dq_out == d && m_addr == a, "R3 write addr/data",
               {m_addr, m_dq_out}, {a, d});
         @(negedge clk);
      end
      check(pins() == 5'b00111, "R3 write end cycle", pins(), 5'b00111);
      check(m_dq_out == d, "R3 data held at commit", m_dq_out, d);
      @(negedge clk);
      check(pins() == 5'b11110, "R1 idle after write", pins(), 5'b11110);
      ref_mem[int'(a)] = d;
      last_was_rd = 1'b0;
   endtask

   task automatic do_read(input logic [AW-1:0] a);
      exp_q.push_back(ref_mem[int'(a)]);
      issue(1'b0, a, 8'h00);
      for (int i = 0; i < EXP_RD; i++) begin
         check(pins() == 5'b00100, "R5 read strobes", pins(), 5'b00100);
         check(m_addr == a, "R5 read address", m_addr, a);
         @(negedge clk);
      end
      check(pins() == 5'b11110, "R1 idle after read", pins(), 5'b11110);
      last_was_rd = 1'b1;
   endtask

   // scoreboard monitor and phase-length monitor
   bit prev_valid = 1'b0;
   int we_low = 0;
   int oe_low = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (rd_valid) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R6 unexpected valid", 32'd1, 32'd0);
            end else begin
               logic [DW-1:0] e;
               e = exp_q.pop_front();
               check(rd_data == e, "R4 read data", rd_data, e);
            end
            check(!prev_valid, "R6 valid longer than one cycle", 32'(prev_valid), 32'd0);
         end
         prev_valid = rd_valid;
         if (!m_we_n) we_low++;
         else if (we_low > 0) begin
            check(we_low == EXP_WP, "R11 write strobe length", we_low, EXP_WP);
            we_low = 0;
         end
         if (!m_oe_n) oe_low++;
         else if (oe_low > 0) begin
            check(oe_low == EXP_RD, "R11 read strobe length", oe_low, EXP_RD);
            oe_low = 0;
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      check(1'b0, "watchdog expired", 32'd0, 32'd1);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check(pins() == 5'b11110 && !rd_valid, "R1 reset state", {pins(), rd_valid},
            6'b111100);
      rst_n = 1'b1;
      @(negedge clk);
      check(pins() == 5'b11110 && !rd_valid, "R1 idle after reset", {pins(), rd_valid},
            6'b111100);

      do_write(17'h00000, 8'h3C);      // first request: no turnaround (R8)
      do_write(17'h1FFFF, 8'hC3);      // back to back: no turnaround (R8)
      do_read (17'h00000);
      do_read (17'h1FFFF);
      do_write(17'h0AAAA, 8'h5A);      // after read: turnaround (R7)
      do_read (17'h0AAAA);
      do_write(17'h15555, 8'hFF);
      do_write(17'h00000, 8'h00);      // overwrite
      do_read (17'h00000);
      do_read (17'h15555);
      for (int i = 1; i < 9; i++) begin
         do_write(AW'(i * 17'h3001), DW'(i * 37));
         do_read (AW'(i * 17'h3001));
      end
      repeat (4) @(negedge clk);
      check(exp_q.size() == 0, "R6 all reads returned", exp_q.size(), 0);
      finish_run();
   end

endmodule